// File: doc/BRIEF.md
# Integer and Bitfield Execute Unit

This block is the integer execute stage of a 32-bit load/store processor core. Each cycle it takes an already decoded operation code, two register operands, a shift amount and the position and width of a bit field. One clock edge later it presents the result on a registered output. The operations are:

- wrapping add and subtract
- the four logical operations
- signed and unsigned set-on-less-than
- fixed and variable shifts and rotates
- byte and halfword sign extension
- byte swap inside each halfword
- load-upper-immediate
- bit field extract and insert

Operand `a_i` is the first source register and `b_i` is the second. For insert, `b_i` is the destination word being modified. An operation code that is not assigned yields a zero result and raises a flag in the same registered cycle. There is no overflow or exception signalling of any kind.

Top module: `ibf_alu`

## Requirements
- R1: The synchronous active-high `rst` clears `result_o` and `illegal_o` to zero. Outside reset, the outputs show the result of the inputs sampled at the previous rising clock edge.
- R2: Code 0 gives a_i+b_i and code 1 gives a_i-b_i, both modulo 2^32, with no overflow indication.
- R3: Code 2 gives AND, code 3 gives OR, code 4 gives XOR and code 5 gives NOR, the complement of a_i|b_i.
- R4: Code 6 compares a_i<b_i as signed and code 7 compares as unsigned. Each writes 32'd1 when the condition holds and 32'd0 otherwise.
- R5: Codes 8, 9 and 10 shift b_i by shamt_i: left logical, right logical and right arithmetic respectively.
- R6: Codes 12, 13 and 14 perform the same three shifts on b_i, but the amount is a_i[4:0] and the higher bits of a_i are ignored.
- R7: Rotate right of b_i uses code 11 with amount shamt_i and code 15 with amount a_i[4:0]. Bits leaving bit 0 re-enter at bit 31.
- R8: Code 16 sign-extends b_i[7:0] to 32 bits and code 17 sign-extends b_i[15:0].
- R9: Code 18 yields {b_i[23:16], b_i[31:24], b_i[7:0], b_i[15:8]}.
- R10: Code 19 yields {b_i[15:0], 16'h0000}.
- R11: Code 20 yields bits fpos_i to fpos_i+fsize_i-1 of a_i, zero-extended, for 1<=fsize_i<=32 and fpos_i+fsize_i<=32.
- R12: Code 21 yields b_i with bits fpos_i to fpos_i+fsize_i-1 replaced by a_i[fsize_i-1:0]. Every other bit of b_i is kept. The legal range is the same as for R11.
- R13: Codes 22 to 31 give result 0 with illegal_o=1. Every other code gives illegal_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 5 | Decoded operation code |
| a_i | input | 32 | First source operand, variable shift amount, insert source |
| b_i | input | 32 | Second source operand, shift and extend input, insert destination |
| shamt_i | input | 5 | Fixed shift or rotate amount |
| fpos_i | input | 5 | Bit field start position |
| fsize_i | input | 6 | Bit field width, 1 to 32 |
| result_o | output | 32 | Registered result |
| illegal_o | output | 1 | Registered unassigned-code flag |

## Verification
Three behaviours are the hardest to provoke from the ports.

- The variable shift forms must ignore a_i above bit 4. The stimulus puts amounts such as 36, 0x3F and 0xFFFFFFE1 on a_i. Each of these gives a visibly wrong result if the high bits leak into the shift.
- The bit field operations are most fragile at the full-width field and at a field that touches bit 31. Extracts and inserts with width 32 at position 0, and with position 31 or 28 at the top edge, exercise the width-to-mask arithmetic at both its ends.
- The insert tests use an all-ones or all-zeros destination. This way, any disturbed bit outside the field shows in the result.

// File: rtl/ibf_alu_pkg.sv
package ibf_alu_pkg;
  localparam int OPW = 5;

  typedef enum logic [OPW-1:0] {
    OP_ADD   = 5'd0,
    OP_SUB   = 5'd1,
    OP_AND   = 5'd2,
    OP_OR    = 5'd3,
    OP_XOR   = 5'd4,
    OP_NOR   = 5'd5,
    OP_SLT   = 5'd6,
    OP_SLTU  = 5'd7,
    OP_SLL   = 5'd8,
    OP_SRL   = 5'd9,
    OP_SRA   = 5'd10,
    OP_ROTR  = 5'd11,
    OP_SLLV  = 5'd12,
    OP_SRLV  = 5'd13,
    OP_SRAV  = 5'd14,
    OP_ROTRV = 5'd15,
    OP_SEB   = 5'd16,
    OP_SEH   = 5'd17,
    OP_SWPH  = 5'd18,
    OP_LUI   = 5'd19,
    OP_FEXT  = 5'd20,
    OP_FINS  = 5'd21
  } op_e;

  typedef enum logic [1:0] {
    SH_LL  = 2'd0,
    SH_RL  = 2'd1,
    SH_RA  = 2'd2,
    SH_ROT = 2'd3
  } shkind_e;
endpackage

// File: rtl/ibf_shifter.sv
module ibf_shifter
  import ibf_alu_pkg::*;
#(
  parameter int DW = 32,
  localparam int SW = $clog2(DW)
) (
  input  shkind_e          kind_i,
  input  logic [SW-1:0]    amt_i,
  input  logic [DW-1:0]    val_i,
  output logic [DW-1:0]    res_o
);
  logic [SW:0] back_amt;

  always_comb begin
    back_amt = (SW+1)'(DW) - {1'b0, amt_i};
    unique case (kind_i)
      SH_LL:   res_o = val_i << amt_i;
      SH_RL:   res_o = val_i >> amt_i;
      SH_RA:   res_o = DW'($signed(val_i) >>> amt_i);
      default: res_o = (val_i >> amt_i) | ((amt_i == '0) ? '0 : (val_i << back_amt));
    endcase
  end
endmodule

// File: rtl/ibf_bitfield.sv
module ibf_bitfield #(
  parameter int DW = 32,
  localparam int SW = $clog2(DW)
) (
  input  logic [DW-1:0] src_i,
  input  logic [DW-1:0] dst_i,
  input  logic [SW-1:0] pos_i,
  input  logic [SW:0]   size_i,
  output logic [DW-1:0] ext_o,
  output logic [DW-1:0] ins_o
);
  logic [DW:0]   wide_mask;
  logic [DW-1:0] low_mask;
  logic [DW-1:0] place_mask;

  always_comb begin
    wide_mask  = ({{DW{1'b0}}, 1'b1} << size_i) - 1'b1;
    low_mask   = wide_mask[DW-1:0];
    place_mask = low_mask << pos_i;
    ext_o      = (src_i >> pos_i) & low_mask;
    ins_o      = (dst_i & ~place_mask) | ((src_i << pos_i) & place_mask);
  end
endmodule

// File: rtl/ibf_alu.sv
module ibf_alu
  import ibf_alu_pkg::*;
#(
  parameter int DW = 32,
  localparam int SW = $clog2(DW),
  localparam int HW = DW / 2,
  localparam int NHALF = DW / 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [4:0]     op_i,
  input  logic [DW-1:0]  a_i,
  input  logic [DW-1:0]  b_i,
  input  logic [SW-1:0]  shamt_i,
  input  logic [SW-1:0]  fpos_i,
  input  logic [SW:0]    fsize_i,
  output logic [DW-1:0]  result_o,
  output logic           illegal_o
);
  op_e           op;
  shkind_e       sh_kind;
  logic [SW-1:0] sh_amt;
  logic [DW-1:0] sh_res;
  logic [DW-1:0] bf_ext;
  logic [DW-1:0] bf_ins;
  logic [DW-1:0] swapped;
  logic [DW-1:0] diff;
  logic          lt_signed;
  logic          lt_unsigned;
  logic [DW-1:0] nxt_res;
  logic          nxt_ill;

  assign op      = op_e'(op_i);
  assign sh_kind = shkind_e'(op_i[1:0]);
  assign sh_amt  = op_i[2] ? a_i[SW-1:0] : shamt_i;

  ibf_shifter #(.DW(DW)) u_shift (
    .kind_i (sh_kind),
    .amt_i  (sh_amt),
    .val_i  (b_i),
    .res_o  (sh_res)
  );

  ibf_bitfield #(.DW(DW)) u_field (
    .src_i  (a_i),
    .dst_i  (b_i),
    .pos_i  (fpos_i),
    .size_i (fsize_i),
    .ext_o  (bf_ext),
    .ins_o  (bf_ins)
  );

  for (genvar h = 0; h < NHALF; h++) begin : g_swap
    assign swapped[h*16 +: 8]     = b_i[h*16+8 +: 8];
    assign swapped[h*16+8 +: 8]   = b_i[h*16 +: 8];
  end

  always_comb begin
    diff        = a_i - b_i;
    lt_unsigned = a_i < b_i;
    lt_signed   = (a_i[DW-1] ^ b_i[DW-1]) ? a_i[DW-1] : diff[DW-1];
    nxt_ill     = 1'b0;
    unique case (op)
      OP_ADD:  nxt_res = a_i + b_i;
      OP_SUB:  nxt_res = diff;
      OP_AND:  nxt_res = a_i & b_i;
      OP_OR:   nxt_res = a_i | b_i;
      OP_XOR:  nxt_res = a_i ^ b_i;
      OP_NOR:  nxt_res = ~(a_i | b_i);
      OP_SLT:  nxt_res = {{(DW-1){1'b0}}, lt_signed};
      OP_SLTU: nxt_res = {{(DW-1){1'b0}}, lt_unsigned};
      OP_SLL, OP_SRL, OP_SRA, OP_ROTR,
      OP_SLLV, OP_SRLV, OP_SRAV, OP_ROTRV: nxt_res = sh_res;
      OP_SEB:  nxt_res = {{(DW-8){b_i[7]}}, b_i[7:0]};
      OP_SEH:  nxt_res = {{(DW-16){b_i[15]}}, b_i[15:0]};
      OP_SWPH: nxt_res = swapped;
      OP_LUI:  nxt_res = {b_i[HW-1:0], {HW{1'b0}}};
      OP_FEXT: nxt_res = bf_ext;
      OP_FINS: nxt_res = bf_ins;
      default: begin
        nxt_res = '0;
        nxt_ill = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result_o  <= '0;
      illegal_o <= 1'b0;
    end else begin
      result_o  <= nxt_res;
      illegal_o <= nxt_ill;
    end
  end

  a_r13_illegal_zero: assert property (@(posedge clk) disable iff (rst)
    illegal_o |-> (result_o == '0));

  a_r2_add_wraps: assert property (@(posedge clk) disable iff (rst)
    (op_i == 5'd0) |=> (result_o == $past(a_i) + $past(b_i)) && !illegal_o);

  a_r4_slt_boolean: assert property (@(posedge clk) disable iff (rst)
    (op_i == 5'd6 || op_i == 5'd7) |=> (result_o[DW-1:1] == '0));

  a_r10_lui_layout: assert property (@(posedge clk) disable iff (rst)
    (op_i == 5'd19) |=> (result_o[HW-1:0] == '0) &&
                        (result_o[DW-1:HW] == $past(b_i[HW-1:0])));

  a_r8_seb_sign: assert property (@(posedge clk) disable iff (rst)
    (op_i == 5'd16) |=> (result_o[DW-1:8] == {(DW-8){$past(b_i[7])}}));
endmodule

// File: tb/ibf_alu_tb.sv
module ibf_alu_tb;
  typedef struct packed {
    logic [4:0]  op;
    logic [31:0] a;
    logic [31:0] b;
    logic [4:0]  sh;
    logic [4:0]  pos;
    logic [5:0]  size;
    logic [31:0] exp;
    logic        ill;
  } vec_t;

  localparam int NV = 31;
  localparam vec_t VECS [NV] = '{
    '{5'd0,  32'hFFFFFFFF, 32'h00000002, 5'd0,  5'd0,  6'd0,  32'h00000001, 1'b0}, // R2 wrap
    '{5'd1,  32'h00000001, 32'h00000002, 5'd0,  5'd0,  6'd0,  32'hFFFFFFFF, 1'b0}, // R2 borrow
    '{5'd2,  32'hF0F0F0F0, 32'hFF00FF00, 5'd0,  5'd0,  6'd0,  32'hF000F000, 1'b0}, // R3
    '{5'd3,  32'hF0F0F0F0, 32'hFF00FF00, 5'd0,  5'd0,  6'd0,  32'hFFF0FFF0, 1'b0}, // R3
    '{5'd4,  32'hF0F0F0F0, 32'hFF00FF00, 5'd0,  5'd0,  6'd0,  32'h0FF00FF0, 1'b0}, // R3
    '{5'd5,  32'hF0F0F0F0, 32'hFF00FF00, 5'd0,  5'd0,  6'd0,  32'h000F000F, 1'b0}, // R3 nor
    '{5'd6,  32'hFFFFFFFF, 32'h00000001, 5'd0,  5'd0,  6'd0,  32'h00000001, 1'b0}, // R4 signed
    '{5'd7,  32'hFFFFFFFF, 32'h00000001, 5'd0,  5'd0,  6'd0,  32'h00000000, 1'b0}, // R4 unsigned
    '{5'd6,  32'h00000005, 32'h00000005, 5'd0,  5'd0,  6'd0,  32'h00000000, 1'b0}, // R4 equal
    '{5'd7,  32'h00000003, 32'h80000000, 5'd0,  5'd0,  6'd0,  32'h00000001, 1'b0}, // R4 unsigned
    '{5'd8,  32'h00000000, 32'h80000001, 5'd4,  5'd0,  6'd0,  32'h00000010, 1'b0}, // R5
    '{5'd9,  32'h00000000, 32'h80000000, 5'd31, 5'd0,  6'd0,  32'h00000001, 1'b0}, // R5
    '{5'd10, 32'h00000000, 32'h80000000, 5'd4,  5'd0,  6'd0,  32'hF8000000, 1'b0}, // R5
    '{5'd11, 32'h00000000, 32'h12345678, 5'd8,  5'd0,  6'd0,  32'h78123456, 1'b0}, // R7
    '{5'd11, 32'h00000000, 32'h12345678, 5'd0,  5'd0,  6'd0,  32'h12345678, 1'b0}, // R7 zero
    '{5'd12, 32'h00000024, 32'h00000001, 5'd9,  5'd0,  6'd0,  32'h00000010, 1'b0}, // R6
    '{5'd13, 32'hFFFFFFE1, 32'h80000000, 5'd9,  5'd0,  6'd0,  32'h40000000, 1'b0}, // R6
    '{5'd14, 32'h0000003F, 32'h80000000, 5'd0,  5'd0,  6'd0,  32'hFFFFFFFF, 1'b0}, // R6
    '{5'd15, 32'h00000104, 32'h0000000F, 5'd0,  5'd0,  6'd0,  32'hF0000000, 1'b0}, // R7
    '{5'd16, 32'h00000000, 32'h12345680, 5'd0,  5'd0,  6'd0,  32'hFFFFFF80, 1'b0}, // R8
    '{5'd16, 32'h00000000, 32'hFFFFFF7F, 5'd0,  5'd0,  6'd0,  32'h0000007F, 1'b0}, // R8
    '{5'd17, 32'h00000000, 32'h00008001, 5'd0,  5'd0,  6'd0,  32'hFFFF8001, 1'b0}, // R8
    '{5'd18, 32'h00000000, 32'h11223344, 5'd0,  5'd0,  6'd0,  32'h22114433, 1'b0}, // R9
    '{5'd19, 32'h00000000, 32'hABCD1234, 5'd0,  5'd0,  6'd0,  32'h12340000, 1'b0}, // R10
    '{5'd20, 32'h12345678, 32'h00000000, 5'd0,  5'd8,  6'd8,  32'h00000056, 1'b0}, // R11
    '{5'd20, 32'hDEADBEEF, 32'h00000000, 5'd0,  5'd0,  6'd32, 32'hDEADBEEF, 1'b0}, // R11 full
    '{5'd20, 32'h80000000, 32'h00000000, 5'd0,  5'd31, 6'd1,  32'h00000001, 1'b0}, // R11 top
    '{5'd21, 32'h000000AB, 32'hFFFFFFFF, 5'd0,  5'd4,  6'd8,  32'hFFFFFABF, 1'b0}, // R12
    '{5'd21, 32'h12345678, 32'h00000000, 5'd0,  5'd0,  6'd32, 32'h12345678, 1'b0}, // R12 full
    '{5'd21, 32'hFFFFFFFF, 32'h00000000, 5'd0,  5'd28, 6'd4,  32'hF0000000, 1'b0}, // R12 top
    '{5'd22, 32'hFFFFFFFF, 32'hFFFFFFFF, 5'd3,  5'd0,  6'd0,  32'h00000000, 1'b1}  // R13
  };

  logic        clk = 1'b0;
  logic        rst;
  logic [4:0]  op_i;
  logic [31:0] a_i, b_i;
  logic [4:0]  shamt_i, fpos_i;
  logic [5:0]  fsize_i;
  logic [31:0] result_o;
  logic        illegal_o;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  ibf_alu u_dut (
    .clk(clk), .rst(rst), .op_i(op_i), .a_i(a_i), .b_i(b_i),
    .shamt_i(shamt_i), .fpos_i(fpos_i), .fsize_i(fsize_i),
    .result_o(result_o), .illegal_o(illegal_o)
  );

  function automatic string req_of(logic [4:0] op);
    if (op <= 5'd1) return "R2";
    if (op <= 5'd5) return "R3";
    if (op <= 5'd7) return "R4";
    if (op == 5'd11 || op == 5'd15) return "R7";
    if (op <= 5'd10) return "R5";
    if (op <= 5'd14) return "R6";
    if (op <= 5'd17) return "R8";
    if (op == 5'd18) return "R9";
    if (op == 5'd19) return "R10";
    if (op == 5'd20) return "R11";
    if (op == 5'd21) return "R12";
    return "R13";
  endfunction

  task automatic check(string req, logic [31:0] exp_r, logic exp_i);
    checks++;
    if (result_o !== exp_r || illegal_o !== exp_i) begin
      errors++;
      $display("FAIL %s: result=%h illegal=%b expected result=%h illegal=%b",
               req, result_o, illegal_o, exp_r, exp_i);
    end
  endtask

  task automatic drive(vec_t v);
    @(negedge clk);
    op_i = v.op; a_i = v.a; b_i = v.b;
    shamt_i = v.sh; fpos_i = v.pos; fsize_i = v.size;
    @(negedge clk);
  endtask

  initial begin
    rst = 1'b1; op_i = 5'd0; a_i = '0; b_i = '0;
    shamt_i = '0; fpos_i = '0; fsize_i = '0;
    repeat (3) @(negedge clk);
    check("R1", 32'h0, 1'b0);                 // R1 reset state
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i]);
      check(req_of(VECS[i].op), VECS[i].exp, VECS[i].ill);
    end

    // R13 highest unassigned code, followed by recovery to a legal code
    drive('{5'd31, 32'h1, 32'h1, 5'd0, 5'd0, 6'd0, 32'h0, 1'b1});
    check("R13", 32'h0, 1'b1);
    drive('{5'd0, 32'h1, 32'h1, 5'd0, 5'd0, 6'd0, 32'h2, 1'b0});
    check("R13", 32'h2, 1'b0);

    // R6 upper amount bits ignored: a_i = 0xFFFFFFE0 shifts by zero
    drive('{5'd13, 32'hFFFFFFE0, 32'h0000F00F, 5'd7, 5'd0, 6'd0, 32'h0000F00F, 1'b0});
    check("R6", 32'h0000F00F, 1'b0);

    // R1 registered timing: result follows the inputs of the previous edge
    @(negedge clk);
    op_i = 5'd4; a_i = 32'hAAAA5555; b_i = 32'hFFFF0000;
    @(posedge clk); #1;
    check("R1", 32'hAAAA5555 ^ 32'hFFFF0000, 1'b0);
    op_i = 5'd22;
    #1;
    check("R1", 32'hAAAA5555 ^ 32'hFFFF0000, 1'b0);

    // R1 synchronous reset clears a live result
    @(negedge clk);
    op_i = 5'd3; a_i = 32'h12345678; b_i = 32'h0;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R1", 32'h0, 1'b0);
    rst = 1'b0;

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule